// File: doc/BRIEF.md
# Legacy Memory Segment Attribute Decoder

This block sits in a host bridge and steers every CPU memory access below 1 MB. It looks at the access address, whether the access is a read or a write, and an SMM-active flag. From these it decides whether the access goes to main DRAM with writes allowed, goes to DRAM as read-only, or is forwarded to the expansion bus. Firmware sets up this routing through a small bank of byte-wide configuration registers. The registers are written through a simple address/data/strobe port and can be read back on the same port.

The legacy range 0xA0000–0xFFFFF is divided into three areas.
- The 128 KB video window at 0xA0000–0xBFFFF is controlled by a single SMRAM control byte.
- Twelve 16 KB option-ROM segments sit at 0xC0000–0xEFFFF.
- One 64 KB BIOS segment sits at 0xF0000–0xFFFFF.

Each option-ROM segment and the BIOS segment has a 2-bit attribute, and two attributes are packed into one register. Addresses outside the legacy range are not decoded: they go straight to DRAM.

Routing is purely combinational. A configuration write is registered on the clock edge and governs every access presented after that edge.

Top module: `legacy_seg_router`

## Requirements
- R1: After synchronous reset, the seven attribute registers at config addresses 0x59–0x5F read 0x00 and the SMRAM control register at 0x72 reads 0x02. With these values, every legacy address forwards to the bus.
- R2: Config reads return the stored byte at 0x59–0x5F and 0x72. Any other config address reads 0x00, and a write to it changes no register.
- R3: The BIOS segment 0xF0000–0xFFFFF takes its attribute from bits [5:4] of register 0x59. Bits [1:0] of 0x59 have no effect on routing.
- R4: Option segment i (0..11) covers 0xC0000+0x4000·i up to, but not including, 0xC0000+0x4000·(i+1). Its attribute comes from register 0x5A+(i>>1): bits [1:0] when i is even, bits [5:4] when i is odd.
- R5: Attribute 3 routes both reads and writes to DRAM. On a write, dram_we is high.
- R6: Attribute 1 routes reads to DRAM with dram_we low. Writes go to the bus with dram_we low.
- R7: Attributes 0 and 2 route both reads and writes to the bus.
- R8: The window 0xA0000–0xBFFFF routes to DRAM (dram_we follows the access direction) when bit 6 of 0x72 is set, or when smm_active is high and bit 3 of 0x72 is set. Otherwise the window goes to the bus.
- R9: Addresses below 0xA0000 or at and above 0x100000 route to DRAM, with dram_we equal to mem_wr.
- R10: Exactly one of to_dram and to_bus is high for every access. dram_we is high only together with to_dram and a write access.
- R11: A config write at one clock edge affects the routing of an access presented after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Config register address |
| cfg_wdata | input | 8 | Config write data |
| cfg_we | input | 1 | Config write strobe |
| cfg_rdata | output | 8 | Config read data for cfg_addr (combinational) |
| mem_addr | input | ADDR_W | CPU memory access address |
| mem_wr | input | 1 | 1 = write access, 0 = read access |
| smm_active | input | 1 | CPU is in system management mode |
| to_dram | output | 1 | Access is routed to DRAM |
| dram_we | output | 1 | DRAM write is permitted for this access |
| to_bus | output | 1 | Access is forwarded to the expansion bus |

## Verification
Directed accesses probe both edges of the segment boundaries (0xC3FFF/0xC4000, 0xEBFFF/0xEC000, 0xBFFFF/0xC0000, 0xFFFFF/0x100000) with both packed nibbles of a register set to differing attributes. A mistake in the segment index or the nibble selection therefore lands on the wrong route. Each attribute value is applied with both a read and a write, which separates read-only from read-write and from forwarding. The SMRAM byte is tried with the open bit, with the SMM-gated bit under both levels of smm_active, and with neither bit set. Finally, a long run of mixed random config writes (including addresses outside the register bank) and random addresses around the legacy range is compared against a shadow model.

// File: rtl/lsd_pkg.sv
`timescale 1ns/1ps
package lsd_pkg;
    localparam int CFG_AW    = 8;
    localparam int OPT_SEGS  = 12;
    localparam int PAM_REGS  = 1 + (OPT_SEGS + 1) / 2;
    localparam logic [CFG_AW-1:0] PAM_BASE   = 8'h59;
    localparam logic [CFG_AW-1:0] SMRAM_ADDR = 8'h72;
    localparam logic [7:0]        SMRAM_RST  = 8'h02;
    localparam int SMRAM_OPEN_BIT = 6;
    localparam int SMRAM_SMM_BIT  = 3;

    localparam logic [19:0] VIDEO_LO = 20'hA0000;
    localparam logic [19:0] OPT_LO   = 20'hC0000;
    localparam logic [19:0] BIOS_LO  = 20'hF0000;
    localparam int SEG_SHIFT = 14;

    typedef enum logic [1:0] {
        ATTR_FWD_A  = 2'd0,
        ATTR_DRAM_RO = 2'd1,
        ATTR_FWD_B  = 2'd2,
        ATTR_DRAM_RW = 2'd3
    } attr_e;

    typedef enum logic [1:0] {
        RGN_OUTSIDE = 2'd0,
        RGN_VIDEO   = 2'd1,
        RGN_OPTION  = 2'd2,
        RGN_BIOS    = 2'd3
    } region_e;

    typedef struct packed {
        logic dram;
        logic we;
        logic bus;
    } route_t;

    function automatic route_t route_plain(input logic wr);
        route_t r;
        r.dram = 1'b1;
        r.we   = wr;
        r.bus  = 1'b0;
        return r;
    endfunction

    function automatic route_t route_fwd();
        route_t r;
        r.dram = 1'b0;
        r.we   = 1'b0;
        r.bus  = 1'b1;
        return r;
    endfunction

    function automatic route_t route_attr(input attr_e a, input logic wr);
        case (a)
            ATTR_DRAM_RW: return route_plain(wr);
            ATTR_DRAM_RO: return wr ? route_fwd() : route_plain(1'b0);
            default:      return route_fwd();
        endcase
    endfunction
endpackage

// File: rtl/lsd_cfg_regs.sv
`timescale 1ns/1ps
module lsd_cfg_regs
    import lsd_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [CFG_AW-1:0]               cfg_addr,
    input  logic [7:0]                      cfg_wdata,
    input  logic                            cfg_we,
    output logic [7:0]                      cfg_rdata,
    output logic [PAM_REGS-1:0][7:0]        pam_bytes,
    output logic [7:0]                      smram_byte
);
    logic [CFG_AW-1:0] rel;
    logic              in_pam;
    assign rel    = cfg_addr - PAM_BASE;
    assign in_pam = (cfg_addr >= PAM_BASE) && (rel < CFG_AW'(PAM_REGS));

    for (genvar g = 0; g < PAM_REGS; g++) begin : g_pam
        always_ff @(posedge clk) begin
            if (rst)
                pam_bytes[g] <= 8'h00;
            else if (cfg_we && in_pam && rel == CFG_AW'(g))
                pam_bytes[g] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            smram_byte <= SMRAM_RST;
        else if (cfg_we && cfg_addr == SMRAM_ADDR)
            smram_byte <= cfg_wdata;
    end

    always_comb begin
        cfg_rdata = 8'h00;
        if (in_pam)
            cfg_rdata = pam_bytes[rel[$clog2(PAM_REGS)-1:0]];
        else if (cfg_addr == SMRAM_ADDR)
            cfg_rdata = smram_byte;
    end

    // R1: reset values present on the first cycle out of reset
    p_rst_smram_r1: assert property (@(posedge clk) $fell(rst) |-> smram_byte == SMRAM_RST && pam_bytes == '0)
        else $error("p_rst_smram_r1");
    // R11: SMRAM write visible after the edge
    p_smram_write_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_addr == SMRAM_ADDR |=> smram_byte == $past(cfg_wdata))
        else $error("p_smram_write_r11");
    // R2: no write strobe, no register change
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(smram_byte) && $stable(pam_bytes))
        else $error("p_hold_r2");
endmodule

// File: rtl/lsd_seg_lookup.sv
`timescale 1ns/1ps
module lsd_seg_lookup
    import lsd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [PAM_REGS-1:0][7:0] pam_bytes,
    input  logic [7:0]               smram_byte,
    input  logic                     smm_active,
    output region_e                  region,
    output attr_e                    attr,
    output logic                     window_open
);
    localparam int IDX_W = 4;

    logic [19:0]      low;
    logic             below_1m;
    logic [19:0]      opt_off;
    logic [IDX_W-1:0] seg_idx;
    attr_e            opt_attr [OPT_SEGS];
    attr_e            bios_attr;

    assign low      = addr[19:0];
    assign below_1m = (addr[ADDR_W-1:20] == '0);
    assign opt_off  = low - OPT_LO;
    assign seg_idx  = opt_off[SEG_SHIFT +: IDX_W];

    for (genvar i = 0; i < OPT_SEGS; i++) begin : g_opt
        localparam int BYTE_SEL = 1 + i / 2;
        localparam int LSB      = (i % 2 == 1) ? 4 : 0;
        assign opt_attr[i] = attr_e'(pam_bytes[BYTE_SEL][LSB +: 2]);
    end

    assign bios_attr = attr_e'(pam_bytes[0][5:4]);

    assign window_open = smram_byte[SMRAM_OPEN_BIT]
                       || (smm_active && smram_byte[SMRAM_SMM_BIT]);

    always_comb begin
        region = RGN_OUTSIDE;
        attr   = ATTR_FWD_A;
        if (below_1m && low >= VIDEO_LO) begin
            if (low < OPT_LO) begin
                region = RGN_VIDEO;
            end else if (low < BIOS_LO) begin
                region = RGN_OPTION;
                if (seg_idx < IDX_W'(OPT_SEGS))
                    attr = opt_attr[seg_idx];
            end else begin
                region = RGN_BIOS;
                attr   = bios_attr;
            end
        end
    end

    logic unused_bits;
    assign unused_bits = ^{opt_off[SEG_SHIFT-1:0], opt_off[19:SEG_SHIFT+IDX_W]};
endmodule

// File: rtl/legacy_seg_router.sv
`timescale 1ns/1ps
module legacy_seg_router
    import lsd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_we,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wr,
    input  logic              smm_active,
    output logic              to_dram,
    output logic              dram_we,
    output logic              to_bus
);
    logic [PAM_REGS-1:0][7:0] pam_bytes;
    logic [7:0]               smram_byte;
    region_e                  region;
    attr_e                    attr;
    logic                     window_open;
    route_t                   rt;

    lsd_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_we     (cfg_we),
        .cfg_rdata  (cfg_rdata),
        .pam_bytes  (pam_bytes),
        .smram_byte (smram_byte)
    );

    lsd_seg_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .addr        (mem_addr),
        .pam_bytes   (pam_bytes),
        .smram_byte  (smram_byte),
        .smm_active  (smm_active),
        .region      (region),
        .attr        (attr),
        .window_open (window_open)
    );

    always_comb begin
        case (region)
            RGN_VIDEO:  rt = window_open ? route_plain(mem_wr) : route_fwd();
            RGN_OPTION,
            RGN_BIOS:   rt = route_attr(attr, mem_wr);
            default:    rt = route_plain(mem_wr);
        endcase
    end

    assign to_dram = rt.dram;
    assign dram_we = rt.we;
    assign to_bus  = rt.bus;

    // R10: exactly one destination
    p_one_dest_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({to_dram, to_bus}) == 1)
        else $error("p_one_dest_r10");
    // R10: write enable only with DRAM and a write
    p_we_qual_r10: assert property (@(posedge clk) disable iff (rst)
        dram_we |-> to_dram && mem_wr)
        else $error("p_we_qual_r10");
    // R8: opened video window reaches DRAM
    p_video_open_r8: assert property (@(posedge clk) disable iff (rst)
        region == RGN_VIDEO && smram_byte[SMRAM_OPEN_BIT] |-> to_dram && dram_we == mem_wr)
        else $error("p_video_open_r8");
    // R9: outside the legacy range goes to DRAM
    p_outside_r9: assert property (@(posedge clk) disable iff (rst)
        region == RGN_OUTSIDE |-> to_dram && dram_we == mem_wr)
        else $error("p_outside_r9");
    // R6: write into read-only segment is forwarded
    p_ro_write_r6: assert property (@(posedge clk) disable iff (rst)
        (region == RGN_OPTION || region == RGN_BIOS) && attr == ATTR_DRAM_RO && mem_wr
        |-> to_bus && !dram_we)
        else $error("p_ro_write_r6");
endmodule

// File: tb/tb_legacy_seg_router.sv
`timescale 1ns/1ps
module tb_legacy_seg_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_addr = 8'h00, cfg_wdata = 8'h00, cfg_rdata;
    logic        cfg_we = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic        mem_wr = 1'b0, smm_active = 1'b0;
    logic        to_dram, dram_we, to_bus;

    always #10 clk = ~clk;

    legacy_seg_router #(.ADDR_W(32)) dut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .smm_active(smm_active), .to_dram(to_dram),
        .dram_we(dram_we), .to_bus(to_bus)
    );

    typedef struct {
        bit         is_read;
        logic [7:0] rd;
        logic [2:0] route;
        string      tag;
    } exp_t;

    exp_t       q[$];
    int         n_vec = 0, n_bad = 0;
    bit         finished = 0;
    logic [7:0] sh_pam [7];
    logic [7:0] sh_smram;

    function automatic logic [2:0] by_attr(input logic [1:0] a, input logic wr);
        if (a == 2'd3) return {1'b1, wr, 1'b0};
        if (a == 2'd1) return wr ? 3'b001 : 3'b100;
        return 3'b001;
    endfunction

    function automatic logic [2:0] model(input logic [31:0] a, input logic wr, input logic smm);
        int i;
        logic [7:0] b;
        if (a >= 32'hA0000 && a < 32'hC0000) begin
            if (sh_smram[6] || (smm && sh_smram[3])) return {1'b1, wr, 1'b0};
            return 3'b001;
        end
        if (a >= 32'hC0000 && a < 32'hF0000) begin
            i = int'((a - 32'hC0000) / 32'h4000);
            b = sh_pam[1 + i / 2];
            return by_attr((i % 2 == 1) ? b[5:4] : b[1:0], wr);
        end
        if (a >= 32'hF0000 && a < 32'h100000) return by_attr(sh_pam[0][5:4], wr);
        return {1'b1, wr, 1'b0};
    endfunction

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        if (a >= 8'h59 && a <= 8'h5F) return sh_pam[a - 8'h59];
        if (a == 8'h72) return sh_smram;
        return 8'h00;
    endfunction

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a >= 8'h59 && a <= 8'h5F) sh_pam[a - 8'h59] = d;
        if (a == 8'h72) sh_smram = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic wr, input logic smm, input string tag);
        exp_t e;
        @(posedge clk); #1;
        mem_addr = a; mem_wr = wr; smm_active = smm;
        e.is_read = 0; e.rd = 8'h00; e.route = model(a, wr, smm); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cfg_read(input logic [7:0] a, input string tag);
        exp_t e;
        @(posedge clk); #1;
        cfg_addr = a;
        e.is_read = 1; e.rd = model_rd(a); e.route = 3'b000; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (e.is_read) begin
                    if (cfg_rdata !== e.rd) begin
                        n_bad++;
                        $display("FAIL %s addr=%h rdata actual=%h expected=%h", e.tag, cfg_addr, cfg_rdata, e.rd);
                    end
                end else if ({to_dram, dram_we, to_bus} !== e.route) begin
                    n_bad++;
                    $display("FAIL %s addr=%h wr=%b smm=%b {dram,we,bus} actual=%b expected=%b",
                             e.tag, mem_addr, mem_wr, smm_active, {to_dram, dram_we, to_bus}, e.route);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 7; k++) sh_pam[k] = 8'h00;
        sh_smram = 8'h02;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset contents and routing
        for (int k = 8'h59; k <= 8'h5F; k++) cfg_read(8'(k), "R1");
        cfg_read(8'h72, "R1");
        access(32'hA0000, 1'b0, 1'b1, "R1");
        access(32'hC0000, 1'b0, 1'b0, "R1");
        access(32'hFFFFF, 1'b1, 1'b0, "R1");
        // R9 outside region
        access(32'h9FFFF, 1'b1, 1'b0, "R9");
        access(32'h100000, 1'b0, 1'b0, "R9");
        access(32'h100000, 1'b1, 1'b0, "R9");
        // R2 unmapped addresses
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_read(8'h58, "R2");
        cfg_read(8'h60, "R2");
        cfg_read(8'h59, "R2");
        access(32'hF0000, 1'b0, 1'b0, "R2");
        // R3 / R5 / R6 / R7 BIOS segment
        cfg_write(8'h59, 8'h30);
        cfg_read(8'h59, "R2");
        access(32'hF0000, 1'b1, 1'b0, "R5");
        access(32'hFFFFF, 1'b0, 1'b0, "R5");
        cfg_write(8'h59, 8'h10);
        access(32'hF8000, 1'b0, 1'b0, "R6");
        access(32'hF8000, 1'b1, 1'b0, "R6");
        cfg_write(8'h59, 8'h23);
        access(32'hF0000, 1'b0, 1'b0, "R3");
        access(32'hF0000, 1'b1, 1'b0, "R7");
        // R4 option segments and nibble selection
        cfg_write(8'h5A, 8'h31);
        access(32'hC3FFF, 1'b0, 1'b0, "R4");
        access(32'hC3FFF, 1'b1, 1'b0, "R4");
        access(32'hC4000, 1'b1, 1'b0, "R4");
        access(32'hBFFFF, 1'b0, 1'b0, "R4");
        cfg_write(8'h5F, 8'h23);
        access(32'hE8000, 1'b1, 1'b0, "R4");
        access(32'hEBFFF, 1'b1, 1'b0, "R4");
        access(32'hEC000, 1'b0, 1'b0, "R4");
        access(32'hEFFFF, 1'b1, 1'b0, "R7");
        // R8 video window
        cfg_write(8'h72, 8'h40);
        access(32'hA0000, 1'b1, 1'b0, "R8");
        access(32'hBFFFF, 1'b0, 1'b0, "R8");
        cfg_write(8'h72, 8'h08);
        access(32'hB0000, 1'b1, 1'b0, "R8");
        access(32'hB0000, 1'b1, 1'b1, "R8");
        cfg_write(8'h72, 8'h02);
        access(32'hB0000, 1'b0, 1'b1, "R8");
        // R11 write directly followed by access
        cfg_write(8'h5C, 8'h03);
        access(32'hD0000, 1'b1, 1'b0, "R11");
        // R10 mixed random run against shadow model
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0)
                cfg_write(8'($urandom_range(8'h57, 8'h74)), 8'($urandom));
            if ($urandom_range(0, 7) == 0)
                cfg_read(8'($urandom_range(8'h57, 8'h74)), "R2");
            access(32'($urandom_range(32'h98000, 32'h108000)), 1'($urandom),
                   1'($urandom), "R10");
        end
        @(posedge clk);
        @(posedge clk);
        finish_run();
    end
endmodule